// File: doc/BRIEF.md
# Two-Port Banked Cache Request Arbiter

This block sits in front of a cache array that is split into several single-ported banks. Each cycle it can take two access requests, one on each request port. It works out which bank each request targets and forwards every request it can to that bank in the same cycle. Each bank receives an enable, the row index inside the bank, and the number of the port it is serving. When both requests target the same bank, one of them is granted. The other sees its ready signal drop. It must hold its address until a later cycle grants it.

Requests are spread across banks by block address: the bits just above the block offset pick the bank. An optional XOR hash folds the lowest tag bits into those bank bits. With the hash, strides that are a multiple of the array size stop landing on one bank. On a conflict, port 0 wins by default. A request that lost a conflict wins any conflict in the next cycle, so neither port can be held off forever. Tag matching and data return belong to the stages behind this block.

Top module: `bank_arbiter`

## Requirements
- R1: After reset, with no request valid, both ready outputs are high and no bank enable is set. The first conflict after reset goes to port 0.
- R2: With HASH_EN = 0, the target bank is address bits [OFF_W +: BANK_W].
- R3: With HASH_EN = 1, the target bank is address bits [OFF_W +: BANK_W] XOR bits [OFF_W+BANK_W+ROW_W +: BANK_W], which are the lowest tag bits.
- R4: Two valid requests to different banks are both granted in the same cycle. Both ready outputs are high and exactly two bank enables are set.
- R5: Two valid requests to the same bank, with no stall pending, grant port 0. Port 1 sees ready low, and only the bank of port 0 is enabled.
- R6: A port whose valid request saw ready low wins any conflict in the following cycle. Its ready is then high, even against a newly arriving request on the other port.
- R7: For each enabled bank, the row output equals address bits [OFF_W+BANK_W +: ROW_W] of the granted request. The source output is 0 for port 0 and 1 for port 1.
- R8: A port without a valid request drives no bank enable and sees ready high. A lone valid request is always granted.
- R9: With 4 banks and two independent, uniformly random requests, about 25% of fresh pairs conflict. A run of several thousand pairs falls between 21% and 29%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, one bit per port |
| req_addr | input | 2×ADDR_W | Request byte address per port |
| req_ready | output | 2 | High when the port's request is accepted this cycle, or when the port is idle |
| bank_en | output | NBANK | Access enable per bank |
| bank_row | output | NBANK×ROW_W | Row index inside each bank |
| bank_src | output | NBANK | Port that owns each enabled bank |

## Verification
The hardest case to reach from the ports is a run of back-to-back conflicts. In that run the stalled request must beat a fresh request that targets the same bank, so priority passes from one port to the other. Directed stimulus builds this case. It holds the losing address and sends a new address on the other port to the same bank, for several cycles in a row. A second pair of addresses collides only under the hash, which separates the two mapping variants. A long run of random pairs then measures the conflict rate.

// File: rtl/bank_arbiter.sv
module bank_arbiter #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int NBANK   = 4,
  parameter int ROW_W   = 8,
  parameter bit HASH_EN = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       req_valid,
  input  logic [1:0][ADDR_W-1:0]           req_addr,
  output logic [1:0]                       req_ready,
  output logic [NBANK-1:0]                 bank_en,
  output logic [NBANK-1:0][ROW_W-1:0]      bank_row,
  output logic [NBANK-1:0]                 bank_src
);
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int ROW_LO = OFF_W + BANK_W;
  localparam int TAG_LO = ROW_LO + ROW_W;

  logic [1:0][BANK_W-1:0] tgt;
  logic [1:0][ROW_W-1:0]  row;
  logic [1:0]             grant;
  logic                   clash;
  logic                   favor1;

  for (genvar p = 0; p < 2; p++) begin : g_map
    if (HASH_EN) begin : g_hash
      assign tgt[p] = req_addr[p][OFF_W +: BANK_W] ^ req_addr[p][TAG_LO +: BANK_W];
    end else begin : g_plain
      assign tgt[p] = req_addr[p][OFF_W +: BANK_W];
    end
    assign row[p] = req_addr[p][ROW_LO +: ROW_W];
  end

  assign clash     = req_valid[0] & req_valid[1] & (tgt[0] == tgt[1]);
  assign grant[0]  = req_valid[0] & ~(clash & favor1);
  assign grant[1]  = req_valid[1] & ~(clash & ~favor1);
  assign req_ready = grant | ~req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) favor1 <= 1'b0;
    else        favor1 <= req_valid[1] & ~grant[1];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit0, hit1;
    assign hit0        = grant[0] & (tgt[0] == BANK_W'(b));
    assign hit1        = grant[1] & (tgt[1] == BANK_W'(b));
    assign bank_en[b]  = hit0 | hit1;
    assign bank_src[b] = hit1;
    assign bank_row[b] = hit1 ? row[1] : row[0];
  end

  a_r5_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready[0] == 1'b0 && req_ready[1] == 1'b0));

  a_r4_pair_served: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == 2'b11 && req_ready == 2'b11) |-> $countones(bank_en) == 2);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == 2'b00) |-> (bank_en == '0));

  a_r7_enables_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_en) == $countones(req_valid & req_ready));

  for (genvar p = 0; p < 2; p++) begin : g_chk
    a_r6_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && !req_ready[p]) |=> (!req_valid[p] || req_ready[p]));
  end
endmodule

// File: tb/test_bank_arbiter.sv
module test_bank_arbiter;
  localparam int PER = 10;
  localparam int AW = 32;
  localparam int NB = 4;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PER/2) clk = ~clk;

  logic [1:0]              v_h, v_p;
  logic [1:0][AW-1:0]      a_h, a_p;
  logic [1:0]              rdy_h, rdy_p;
  logic [NB-1:0]           en_h, en_p, src_h, src_p;
  logic [NB-1:0][RW-1:0]   row_h, row_p;

  bank_arbiter #(.ADDR_W(AW), .OFF_W(6), .NBANK(NB), .ROW_W(RW), .HASH_EN(1'b1)) i_bank_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(v_h), .req_addr(a_h), .req_ready(rdy_h),
    .bank_en(en_h), .bank_row(row_h), .bank_src(src_h));

  bank_arbiter #(.ADDR_W(AW), .OFF_W(6), .NBANK(NB), .ROW_W(RW), .HASH_EN(1'b0)) i_bank_arbiter_plain (
    .clk(clk), .rst_n(rst_n), .req_valid(v_p), .req_addr(a_p), .req_ready(rdy_p),
    .bank_en(en_p), .bank_row(row_p), .bank_src(src_p));

  int nvec = 0, nbad = 0;
  int fresh = 0, confl = 0;
  int hits_seen [NB], hits_exp [NB];
  bit held [2][2];
  bit fav [2];
  bit mv [2][2];
  logic [AW-1:0] ma [2][2];

  always @(posedge clk)
    if (rst_n) for (int b = 0; b < NB; b++) if (en_h[b]) hits_seen[b]++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int r, input int b);
    return AW'((tag << 16) | (r << 8) | (b << 6));
  endfunction

  function automatic int bank_of(input logic [AW-1:0] a, input bit hash);
    int bb = int'(a[7:6]);
    if (hash) bb = bb ^ int'(a[17:16]);
    return bb;
  endfunction

  task automatic cycle(input logic [1:0] nv, input logic [AW-1:0] n0, input logic [AW-1:0] n1);
    bit was_fresh;
    was_fresh = !held[1][0] && !held[1][1];
    for (int d = 0; d < 2; d++) begin
      if (!held[d][0]) begin mv[d][0] = nv[0]; ma[d][0] = n0; end
      if (!held[d][1]) begin mv[d][1] = nv[1]; ma[d][1] = n1; end
    end
    v_h = {mv[1][1], mv[1][0]}; a_h[0] = ma[1][0]; a_h[1] = ma[1][1];
    v_p = {mv[0][1], mv[0][0]}; a_p[0] = ma[0][0]; a_p[1] = ma[0][1];
    #1;
    for (int d = 0; d < 2; d++) begin
      int b0, b1;
      bit cl;
      bit [1:0] g, er;
      logic [1:0] ardy;
      logic [NB-1:0] een, aen, esrc, asrc;
      logic [NB-1:0][RW-1:0] arow;
      string rt, et;
      b0 = bank_of(ma[d][0], d == 1);
      b1 = bank_of(ma[d][1], d == 1);
      cl = mv[d][0] && mv[d][1] && (b0 == b1);
      g[0] = mv[d][0] && !(cl && fav[d]);
      g[1] = mv[d][1] && !(cl && !fav[d]);
      er = g | ~{mv[d][1], mv[d][0]};
      een = '0; esrc = '0;
      if (g[0]) een[b0] = 1'b1;
      if (g[1]) begin een[b1] = 1'b1; esrc[b1] = 1'b1; end
      ardy = (d == 1) ? rdy_h : rdy_p;
      aen  = (d == 1) ? en_h : en_p;
      asrc = (d == 1) ? src_h : src_p;
      arow = (d == 1) ? row_h : row_p;
      if (cl) rt = fav[d] ? "R6 stalled port favoured" : "R5 port 0 wins";
      else if (mv[d][0] && mv[d][1]) rt = "R4 distinct banks";
      else rt = "R8 single or idle port";
      chk(rt, 64'(ardy), 64'(er));
      if (!mv[d][0] && !mv[d][1]) et = "R8 idle enables";
      else et = (d == 1) ? "R3 hashed bank" : "R2 plain bank";
      chk(et, 64'(aen), 64'(een));
      for (int p = 0; p < 2; p++)
        if (g[p]) begin
          int bb = (p == 0) ? b0 : b1;
          chk("R7 row", 64'(arow[bb]), 64'(ma[d][p][15:8]));
          chk("R7 source", 64'(asrc[bb]), 64'(esrc[bb]));
          if (d == 1) hits_exp[bb]++;
        end
      if (d == 1 && was_fresh && mv[1][0] && mv[1][1]) begin
        fresh++;
        if (rdy_h != 2'b11) confl++;
      end
      held[d][0] = mv[d][0] && !g[0];
      held[d][1] = mv[d][1] && !g[1];
      fav[d] = held[d][1];
    end
    @(negedge clk);
  endtask

  initial begin
    #(PER * 200000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    v_h = '0; v_p = '0; a_h = '0; a_p = '0;
    for (int b = 0; b < NB; b++) begin hits_seen[b] = 0; hits_exp[b] = 0; end
    for (int d = 0; d < 2; d++) begin
      fav[d] = 1'b0;
      for (int p = 0; p < 2; p++) begin held[d][p] = 1'b0; mv[d][p] = 1'b0; ma[d][p] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", 64'({rdy_h, rdy_p}), 64'hF);
    chk("R1 no enables after reset", 64'({en_h, en_p}), 64'h0);
    @(negedge clk);
    // R1: first conflict after reset goes to port 0 (R5 path)
    cycle(2'b11, mk(0, 1, 3), mk(0, 2, 3));
    // R6: held port 1 against a new port 0 request to the same bank
    cycle(2'b11, mk(0, 7, 3), mk(0, 0, 0));
    // R6: held port 0 now favoured against a new port 1 request
    cycle(2'b11, mk(0, 0, 0), mk(0, 9, 3));
    cycle(2'b00, '0, '0);
    cycle(2'b00, '0, '0);
    // R8: lone requests
    cycle(2'b01, mk(0, 5, 1), mk(0, 5, 1));
    cycle(2'b10, mk(0, 6, 2), mk(0, 6, 2));
    // R4: distinct banks
    cycle(2'b11, mk(0, 3, 0), mk(0, 4, 2));
    // R2 / R3: collide only when hashed
    cycle(2'b11, mk(1, 10, 0), mk(0, 11, 1));
    cycle(2'b00, '0, '0);
    // R3: collide only without hash
    cycle(2'b11, mk(2, 12, 1), mk(0, 13, 1));
    cycle(2'b00, '0, '0);
    fresh = 0; confl = 0;
    for (int i = 0; i < 4000; i++)
      cycle(2'b11, AW'($urandom), AW'($urandom));
    cycle(2'b00, '0, '0);
    // R9: conflict rate near one quarter
    nvec++;
    if (confl * 100 < fresh * 21 || confl * 100 > fresh * 29) begin
      nbad++;
      $display("FAIL R9 conflict rate: actual %0d/%0d expected about 25%%", confl, fresh);
    end
    for (int b = 0; b < NB; b++) chk("R7 bank access count", 64'(hits_seen[b]), 64'(hits_exp[b]));
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule